// File: doc/BRIEF.md
# Triple Serial Channel Register Bank

This block is the register front end for three byte-oriented serial channels. A host reaches it over a simple bus. Each access carries an address, a size bit (one or two bytes), a read strobe, a write strobe and write data. The bank decodes the offset and checks that the access size suits the target register. It also refuses writes that would set protected bits. An illegal access produces a one-cycle pulse on `bus_err` and changes nothing.

Every channel holds five registers: a 16-bit control word, an 8-bit interrupt-mode byte, a transmit byte, a receive byte and a status word. The last channel also owns a timer byte. Received bytes arrive on a valid/data pair per channel. When a byte arrives, the bank loads the receive byte, raises the ready flag and pulses the channel's receive event output. A legal write to a transmit byte pulses that channel's transmit event output. Bit-level serialisation and baud timing live elsewhere.

Each channel runs a two-state receive machine:

| State | Meaning |
|-------|---------|
| `RX_EMPTY` | No unread byte is held. |
| `RX_FULL` | An unread byte is held and the ready flag reads as 1. |

| Transition | Condition |
|------------|-----------|
| EMPTY→FULL | A receive valid pulse arrives. |
| FULL→FULL | A valid pulse arrives, which overwrites the byte. |
| FULL→EMPTY | The receive byte is read with no valid pulse in the same cycle. |

While the machine is in `RX_EMPTY`, a status read refills the receive byte with zero.

Top module: `sio_bank`

## Requirements
- R1: After reset every register reads as zero, and `bus_err`, `bus_rdata`, `rx_evt` and `tx_evt` are zero.
- R2: Channel c's registers sit at offsets c*16 + {0 control, 4 interrupt mode, 8 transmit, 9 receive, 12 status}. `bus_size` = 0 selects a one-byte access and 1 selects a two-byte access. The control word accepts only two-byte accesses. On channel 2, a control write with any of bits 0x0C04 set is an error and leaves the word unchanged.
- R3: Interrupt-mode bytes accept only one-byte accesses. A write that sets any bit of 0x4A (channels 0 and 1) or 0xCA (channel 2) is an error and leaves the byte unchanged.
- R4: A one-byte write to a transmit byte stores the byte, and reads back unchanged. It also pulses `tx_evt[c]` for one cycle in the same cycle that the write's response appears. A two-byte access to a transmit byte is an error.
- R5: A `rx_valid[c]` pulse loads `rx_data[8c+7:8c]` into the receive byte and sets status bit 4. It also pulses `rx_evt[c]` one cycle later.
- R6: A one-byte read of the receive byte returns the held byte and clears status bit 4. Any other access to the receive byte is an error.
- R7: A status read while the ready flag is clear, with no valid pulse in that cycle, sets the receive byte to zero.
- R8: A one-byte status read is legal on every channel. A two-byte status read is legal on channels 0 and 1 and an error on channel 2. Any status write is an error.
- R9: An access is an error in any of these cases: it targets an unmapped offset, including the window at 0x30–0x3F; it targets offset 13 outside channel 2; both strobes are asserted together. An erroring access returns zero read data and changes no state.
- R10: Channel 2's timer byte at offset 0x2D is read and written only with one-byte accesses.
- R11: A valid pulse while the flag is set overwrites the byte and keeps the flag set. When a receive-byte read and a valid pulse land in the same cycle, the read returns the old byte, and the new byte is kept with the flag still set.
- R12: Read data and the error pulse appear exactly one cycle after the access, and last one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_size | input | 1 | 0 = one byte, 1 = two bytes |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data, low byte used for byte registers |
| bus_rdata | output | 16 | Read data, registered, zero when no legal read |
| bus_err | output | 1 | One-cycle pulse after an illegal access |
| rx_valid | input | 3 | Per-channel received-byte strobe |
| rx_data | input | 24 | Received bytes, channel c in bits 8c+7:8c |
| rx_evt | output | 3 | Per-channel receive event pulse |
| tx_evt | output | 3 | Per-channel transmit event pulse |

## Verification
The assertions rest on three assumptions about the inputs. Each access lasts a single cycle. At most one access is in flight. The protected-bit checks see write data that is stable in the strobe cycle. The bench follows all three by driving every access on the falling edge and dropping the strobes after one cycle. It leaves an idle cycle between accesses and raises receive strobes only on the falling edge, alone or alongside one access. Expected results come from an arithmetic legality function and shadow copies of the writable registers. The bench applies these in sweeps over every offset and size, and over every single bit of the control and interrupt-mode words.

// File: rtl/sio_pkg.sv
package sio_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_ICR,
        SEL_TXB,
        SEL_RXB,
        SEL_STAT,
        SEL_TIM
    } reg_sel_e;

    typedef enum logic {
        RX_EMPTY,
        RX_FULL
    } rx_state_e;

endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_pkg::*;
#(
    parameter int          ADDR_W       = 6,
    parameter int          N_CH         = 3,
    parameter int          DATA_W       = 16,
    parameter logic [15:0] CTRL_RO_LAST = 16'h0C04,
    parameter logic [7:0]  ICR_RO       = 8'h4A,
    parameter logic [7:0]  ICR_RO_LAST  = 8'hCA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output reg_sel_e          sel,
    output logic [ADDR_W-5:0] ch,
    output logic              ok
);
    localparam int CH_W = ADDR_W - 4;
    localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

    logic [3:0] off;
    logic       last;
    logic       mapped;
    logic       legal;

    assign ch     = addr[ADDR_W-1:4];
    assign off    = addr[3:0];
    assign last   = (ch == LAST_CH);
    assign mapped = (ch <= LAST_CH);

    always_comb begin
        sel   = SEL_NONE;
        legal = 1'b0;
        case (off)
            4'h0: begin
                sel   = SEL_CTRL;
                legal = size && !(wr && last && (|(wdata & CTRL_RO_LAST)));
            end
            4'h4: begin
                sel   = SEL_ICR;
                legal = !size && !(wr && (|(wdata[7:0] & (last ? ICR_RO_LAST : ICR_RO))));
            end
            4'h8: begin
                sel   = SEL_TXB;
                legal = !size;
            end
            4'h9: begin
                sel   = SEL_RXB;
                legal = !size && !wr;
            end
            4'hC: begin
                sel   = SEL_STAT;
                legal = !wr && (!size || !last);
            end
            4'hD: begin
                sel   = SEL_TIM;
                legal = last && !size;
            end
            default: begin
                sel   = SEL_NONE;
                legal = 1'b0;
            end
        endcase
    end

    assign ok = mapped && legal && (rd ^ wr);

endmodule

// File: rtl/sio_chan.sv
module sio_chan
    import sio_pkg::*;
#(
    parameter int          DATA_W  = 16,
    parameter int          RDY_BIT = 4,
    parameter logic [15:0] RO_CTRL = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              icr_wr,
    input  logic              txb_wr,
    input  logic              rxb_rd,
    input  logic              stat_rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [7:0]        icr_q,
    output logic [7:0]        txb_q,
    output logic [7:0]        rxb_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              rx_evt,
    output logic              tx_evt
);
    rx_state_e state_q, state_d;

    // receive state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            RX_EMPTY: state_d = rx_valid ? RX_FULL : RX_EMPTY;
            RX_FULL:  state_d = (rx_valid || !rxb_rd) ? RX_FULL : RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    // registers and event outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            icr_q  <= '0;
            txb_q  <= '0;
            rxb_q  <= '0;
            rx_evt <= 1'b0;
            tx_evt <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= wdata;
            if (icr_wr)  icr_q  <= wdata[7:0];
            if (txb_wr)  txb_q  <= wdata[7:0];
            if (rx_valid)
                rxb_q <= rx_byte;
            else if (stat_rd && state_q == RX_EMPTY)
                rxb_q <= '0;
            rx_evt <= rx_valid;
            tx_evt <= txb_wr;
        end
    end

    always_comb begin
        stat_q          = '0;
        stat_q[RDY_BIT] = (state_q == RX_FULL);
    end

    // R5
    load_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (state_q == RX_FULL) && rx_evt);

    // R6
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxb_rd && !rx_valid) |=> (state_q == RX_EMPTY));

    // R11
    overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (rxb_q == $past(rx_byte)));

    generate
        if (RO_CTRL != 16'h0000) begin : g_ro
            // R2
            ctrl_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_wr |-> ((wdata & RO_CTRL) == '0));
        end
    endgenerate

endmodule

// File: rtl/sio_bank.sv
module sio_bank
    import sio_pkg::*;
#(
    parameter int          ADDR_W       = 6,
    parameter int          DATA_W       = 16,
    parameter int          N_CH         = 3,
    parameter int          RDY_BIT      = 4,
    parameter logic [15:0] CTRL_RO_LAST = 16'h0C04,
    parameter logic [7:0]  ICR_RO       = 8'h4A,
    parameter logic [7:0]  ICR_RO_LAST  = 8'hCA
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_size,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    input  logic [N_CH-1:0]     rx_valid,
    input  logic [N_CH*8-1:0]   rx_data,
    output logic [N_CH-1:0]     rx_evt,
    output logic [N_CH-1:0]     tx_evt
);
    localparam int CH_W = ADDR_W - 4;

    reg_sel_e          sel;
    logic [CH_W-1:0]   ch;
    logic              ok;

    logic [DATA_W-1:0] ctrl_q [N_CH];
    logic [7:0]        icr_q  [N_CH];
    logic [7:0]        txb_q  [N_CH];
    logic [7:0]        rxb_q  [N_CH];
    logic [DATA_W-1:0] stat_q [N_CH];
    logic [7:0]        tim_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rd_sized;

    sio_decode #(
        .ADDR_W(ADDR_W), .N_CH(N_CH), .DATA_W(DATA_W),
        .CTRL_RO_LAST(CTRL_RO_LAST), .ICR_RO(ICR_RO), .ICR_RO_LAST(ICR_RO_LAST)
    ) u_dec (
        .addr(bus_addr), .size(bus_size), .rd(bus_rd), .wr(bus_wr),
        .wdata(bus_wdata), .sel(sel), .ch(ch), .ok(ok)
    );

    generate
        for (genvar i = 0; i < N_CH; i++) begin : g_ch
            logic hit;
            assign hit = ok && (ch == CH_W'(i));
            sio_chan #(
                .DATA_W(DATA_W), .RDY_BIT(RDY_BIT),
                .RO_CTRL((i == N_CH - 1) ? CTRL_RO_LAST : 16'h0000)
            ) u_chan (
                .clk(clk), .rst_n(rst_n),
                .ctrl_wr(hit && bus_wr && sel == SEL_CTRL),
                .icr_wr (hit && bus_wr && sel == SEL_ICR),
                .txb_wr (hit && bus_wr && sel == SEL_TXB),
                .rxb_rd (hit && bus_rd && sel == SEL_RXB),
                .stat_rd(hit && bus_rd && sel == SEL_STAT),
                .wdata(bus_wdata),
                .rx_valid(rx_valid[i]),
                .rx_byte(rx_data[i*8 +: 8]),
                .ctrl_q(ctrl_q[i]), .icr_q(icr_q[i]), .txb_q(txb_q[i]),
                .rxb_q(rxb_q[i]), .stat_q(stat_q[i]),
                .rx_evt(rx_evt[i]), .tx_evt(tx_evt[i])
            );
        end
    endgenerate

    always_comb begin
        rd_val = '0;
        if (ok) begin
            unique case (sel)
                SEL_CTRL: rd_val = ctrl_q[ch];
                SEL_ICR:  rd_val = DATA_W'(icr_q[ch]);
                SEL_TXB:  rd_val = DATA_W'(txb_q[ch]);
                SEL_RXB:  rd_val = DATA_W'(rxb_q[ch]);
                SEL_STAT: rd_val = stat_q[ch];
                SEL_TIM:  rd_val = DATA_W'(tim_q);
                default:  rd_val = '0;
            endcase
        end
    end

    assign rd_sized = bus_size ? rd_val : DATA_W'(rd_val[7:0]);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tim_q     <= '0;
            bus_rdata <= '0;
            bus_err   <= 1'b0;
        end else begin
            if (ok && bus_wr && sel == SEL_TIM) tim_q <= bus_wdata[7:0];
            bus_rdata <= (ok && bus_rd) ? rd_sized : '0;
            bus_err   <= (bus_rd || bus_wr) && !ok;
        end
    end

    // R9
    err_zero_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    // R4
    tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_evt));

    // R12
    err_follows_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |=> !bus_err);

endmodule

// File: tb/tb_sio_bank.sv
`timescale 1ns/1ps
module tb_sio_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_size = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        bus_err;
    logic [2:0]  rx_valid = '0;
    logic [23:0] rx_data = '0;
    logic [2:0]  rx_evt;
    logic [2:0]  tx_evt;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] g_rdata;
    logic        g_err;
    logic [2:0]  g_rx;
    logic [2:0]  g_tx;

    logic [15:0] sh_ctrl [3];
    logic [7:0]  sh_icr  [3];

    always #4 clk = ~clk;

    sio_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_evt(rx_evt), .tx_evt(tx_evt)
    );

    task automatic check(input logic cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic acc_rx(input logic [5:0] a, input logic sz, input logic r, input logic w,
                          input logic [15:0] d, input logic [2:0] rv, input logic [23:0] rdat);
        @(negedge clk);
        bus_addr = a; bus_size = sz; bus_rd = r; bus_wr = w; bus_wdata = d;
        rx_valid = rv; rx_data = rdat;
        @(negedge clk);
        g_rdata = bus_rdata; g_err = bus_err; g_rx = rx_evt; g_tx = tx_evt;
        bus_rd = 1'b0; bus_wr = 1'b0; rx_valid = '0;
    endtask

    task automatic acc(input logic [5:0] a, input logic sz, input logic r, input logic w, input logic [15:0] d);
        acc_rx(a, sz, r, w, d, 3'b000, 24'h0);
    endtask

    function automatic logic exp_err(input logic [5:0] a, input logic sz, input logic w, input logic [15:0] d);
        logic [1:0] c = a[5:4];
        if (c == 2'd3) return 1'b1;
        case (a[3:0])
            4'h0: return !sz || (w && c == 2 && (d & 16'h0C04) != 0);
            4'h4: return sz || (w && (d[7:0] & ((c == 2) ? 8'hCA : 8'h4A)) != 0);
            4'h8: return sz;
            4'h9: return sz || w;
            4'hC: return w || (sz && c == 2);
            4'hD: return c != 2 || sz;
            default: return 1'b1;
        endcase
    endfunction

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) begin sh_ctrl[i] = '0; sh_icr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        check(bus_rdata == 0 && !bus_err && rx_evt == 0 && tx_evt == 0, "R1 reset outputs",
              {bus_rdata, 1'b0, bus_err, rx_evt, tx_evt}, 0);

        // R1 R2 R8 R9 R10: read sweep over every offset and size
        for (int a = 0; a < 64; a++) begin
            for (int s = 0; s < 2; s++) begin
                acc(6'(a), s[0], 1'b1, 1'b0, 16'h0);
                check(g_err == exp_err(6'(a), s[0], 1'b0, 16'h0), "R9 read legality",
                      {a[15:0], 15'h0, g_err}, {16'h0, 15'h0, exp_err(6'(a), s[0], 1'b0, 16'h0)});
                check(g_rdata == 0, "R1 reset read value", g_rdata, 0);
            end
        end

        // R4 R9: write sweep with zero data
        for (int a = 0; a < 64; a++) begin
            for (int s = 0; s < 2; s++) begin
                logic e;
                logic [2:0] etx;
                e = exp_err(6'(a), s[0], 1'b1, 16'h0);
                etx = (!e && a[3:0] == 4'h8) ? 3'(1 << a[5:4]) : 3'b000;
                acc(6'(a), s[0], 1'b0, 1'b1, 16'h0);
                check(g_err == e, "R9 write legality", {a[15:0], 15'h0, g_err}, {16'h0, 15'h0, e});
                check(g_tx == etx, "R4 tx event on write", g_tx, etx);
            end
        end

        // R9 both strobes together
        acc(6'h00, 1'b1, 1'b1, 1'b1, 16'h0001);
        check(g_err == 1'b1, "R9 read and write together", g_err, 1);
        // R12 error pulse is one cycle
        @(negedge clk);
        check(bus_err == 1'b0, "R12 error pulse single cycle", bus_err, 0);

        // R2 control single-bit sweep
        for (int c = 0; c < 3; c++) begin
            for (int b = 0; b < 16; b++) begin
                logic [15:0] d;
                logic e;
                d = 16'(1 << b);
                e = exp_err(6'(c * 16), 1'b1, 1'b1, d);
                acc(6'(c * 16), 1'b1, 1'b0, 1'b1, d);
                check(g_err == e, "R2 control write legality", g_err, e);
                if (!e) sh_ctrl[c] = d;
                acc(6'(c * 16), 1'b1, 1'b1, 1'b0, 16'h0);
                check(g_rdata == sh_ctrl[c], "R2 control readback", g_rdata, sh_ctrl[c]);
            end
        end

        // R3 interrupt-mode single-bit sweep
        for (int c = 0; c < 3; c++) begin
            for (int b = 0; b < 8; b++) begin
                logic [15:0] d;
                logic e;
                d = 16'(1 << b);
                e = exp_err(6'(c * 16 + 4), 1'b0, 1'b1, d);
                acc(6'(c * 16 + 4), 1'b0, 1'b0, 1'b1, d);
                check(g_err == e, "R3 interrupt-mode write legality", g_err, e);
                if (!e) sh_icr[c] = d[7:0];
                acc(6'(c * 16 + 4), 1'b0, 1'b1, 1'b0, 16'h0);
                check(g_rdata == {8'h0, sh_icr[c]}, "R3 interrupt-mode readback", g_rdata, sh_icr[c]);
            end
        end

        // R4 transmit store and readback
        for (int c = 0; c < 3; c++) begin
            acc(6'(c * 16 + 8), 1'b0, 1'b0, 1'b1, 16'(8'hA5 + c));
            check(g_tx == 3'(1 << c) && !g_err, "R4 tx pulse", g_tx, 3'(1 << c));
            acc(6'(c * 16 + 8), 1'b0, 1'b1, 1'b0, 16'h0);
            check(g_rdata == 16'(8'hA5 + c), "R4 tx readback", g_rdata, 16'(8'hA5 + c));
        end

        // R10 timer byte
        acc(6'h2D, 1'b0, 1'b0, 1'b1, 16'h005C);
        acc(6'h2D, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h005C, "R10 timer readback", g_rdata, 16'h005C);
        acc(6'h2D, 1'b1, 1'b0, 1'b1, 16'h0077);
        check(g_err == 1'b1, "R10 timer two-byte write", g_err, 1);
        acc(6'h2D, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h005C, "R10 timer unchanged", g_rdata, 16'h005C);

        // R5 receive load on channel 1
        acc_rx(6'h00, 1'b0, 1'b0, 1'b0, 16'h0, 3'b010, 24'h003C00);
        check(g_rx == 3'b010, "R5 rx event", g_rx, 3'b010);
        acc(6'h1C, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0010, "R5 ready flag set", g_rdata, 16'h0010);
        // R6 read returns byte and clears flag
        acc(6'h19, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h003C, "R6 rx byte read", g_rdata, 16'h003C);
        acc(6'h1C, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0000, "R6 ready flag cleared", g_rdata, 0);
        // R7 status read while empty zeroes the receive byte
        acc(6'h19, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0000, "R7 rx byte refilled with zero", g_rdata, 0);

        // R11 overwrite while full (channel 0)
        acc_rx(6'h00, 1'b0, 1'b0, 1'b0, 16'h0, 3'b001, 24'h000011);
        acc_rx(6'h00, 1'b0, 1'b0, 1'b0, 16'h0, 3'b001, 24'h000022);
        acc(6'h0C, 1'b1, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0010 && !g_err, "R8 two-byte status on channel 0", g_rdata, 16'h0010);
        acc(6'h09, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0022, "R11 overwrite keeps newest", g_rdata, 16'h0022);
        // R11 read and new byte in the same cycle
        acc_rx(6'h00, 1'b0, 1'b0, 1'b0, 16'h0, 3'b001, 24'h000033);
        acc_rx(6'h09, 1'b0, 1'b1, 1'b0, 16'h0, 3'b001, 24'h000044);
        check(g_rdata == 16'h0033, "R11 same-cycle read returns old", g_rdata, 16'h0033);
        acc(6'h0C, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0010, "R11 flag kept after collision", g_rdata, 16'h0010);
        acc(6'h09, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0044, "R11 new byte kept", g_rdata, 16'h0044);

        // R8 two-byte status on channel 2 is an error
        acc_rx(6'h00, 1'b0, 1'b0, 1'b0, 16'h0, 3'b100, 24'h550000);
        acc(6'h2C, 1'b1, 1'b1, 1'b0, 16'h0);
        check(g_err == 1'b1 && g_rdata == 0, "R8 two-byte status channel 2", {g_rdata, 15'h0, g_err}, 1);
        // R9 status write rejected, flag untouched
        acc(6'h2C, 1'b0, 1'b0, 1'b1, 16'h0000);
        check(g_err == 1'b1, "R9 status write error", g_err, 1);
        acc(6'h2C, 1'b0, 1'b1, 1'b0, 16'h0);
        check(g_rdata == 16'h0010, "R9 status unchanged", g_rdata, 16'h0010);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule